// File: doc/BRIEF.md
# Key-Guarded Watchdog Register Front End

This block decodes bus accesses to a 16-byte watchdog register window and turns them into commands for a separate countdown engine. The window holds a stage-one preload register, a stage-two preload register and a reload register. None of the protected registers can be written directly. Software must first write a two-value key to the reload register. The key grants permission for exactly one later half-word or word write, and that write uses up the permission whether or not it reaches a protected register.

Accepted writes appear on the outputs in the same cycle as the bus write. A preload write produces a load strobe for the selected stage, together with the low 20 bits of the data. A reload write can produce a keep-alive ping, a clear of the previous-reboot flag, or both. The engine supplies the previous-reboot flag, and the block returns it on a half-word read of the reload register. Reads return data combinationally.

Top module: `wdt_regif`

## Requirements
- R1: Access size is encoded on `size_i` as 0 = byte, 1 = half-word (16 bits) and 2 = word (32 bits). Code 3 is handled as a byte access. The value a write carries is `wdata_i` masked to the access width. Offsets are 0x0 for the stage-one preload, 0x4 for the stage-two preload and 0xC for reload.
- R2: A write of value 0x80 to offset 0xC puts the key state into "first key seen", whatever the state was before.
- R3: A write of value 0x86 to offset 0xC while in "first key seen" puts the key state into "unlocked". A 0x86 write made in any other state is an ordinary non-key write.
- R4: While unlocked, a half-word write to 0xC with bit 8 set pulses `ping_o`.
- R5: While unlocked, a half-word write to 0xC with bit 9 or bit 12 set pulses `clr_flag_o`.
- R6: While unlocked, a word write to 0x0 pulses `load_s1_o`, and a word write to 0x4 pulses `load_s2_o`. In both cases `load_val_o` carries `wdata_i[19:0]`.
- R7: A byte-sized write never produces a ping, clear or load. A byte write that is not a key write leaves the key state unchanged.
- R8: Any half-word or word write that is not a key write, made while unlocked, returns the key state to idle, whether or not it hit a protected register.
- R9: A write that is not a key write, made while not unlocked, produces no output and leaves the key state unchanged.
- R10: A half-word read of 0xC returns `flag_i` on bit 9 and on bit 12, with every other bit zero. Every other read, and every cycle without a read, returns zero.
- R11: Ping, clear and load strobes are high only in the cycle of the accepted write, for one cycle.
- R12: Reset puts the key state into idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write access this cycle |
| rd_en_i | input | 1 | Read access this cycle |
| addr_i | input | 4 | Byte offset in the window |
| size_i | input | 2 | Access size code |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data |
| flag_i | input | 1 | Previous-reboot flag from the engine |
| ping_o | output | 1 | Keep-alive ping pulse |
| clr_flag_o | output | 1 | Clear previous-reboot flag pulse |
| load_s1_o | output | 1 | Stage-one preload strobe |
| load_s2_o | output | 1 | Stage-two preload strobe |
| load_val_o | output | 20 | Preload value |

## Verification
The bench uses the default parameters: a 4-bit offset and a 20-bit preload. At this size it can sweep every offset, every size code, a set of data values that covers both keys and every action bit, and each of the three key states as a starting point. Each combination starts from reset. The bench drives a prefix that reaches the starting state, then the write under test, then a fixed probe sequence whose ping result shows the key state that was left behind. A separate sweep reads every offset at every size with the flag both low and high.

// File: rtl/wdt_regif_pkg.sv
package wdt_regif_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    KS_IDLE = 2'd0,
    KS_KEY1 = 2'd1,
    KS_OPEN = 2'd2
  } key_state_e;

  localparam logic [31:0] KEY_FIRST  = 32'h80;
  localparam logic [31:0] KEY_SECOND = 32'h86;
  localparam int PING_BIT  = 8;
  localparam int CLR_BIT_A = 9;
  localparam int CLR_BIT_B = 12;
endpackage

// File: rtl/wdt_regif_keyfsm.sv
module wdt_regif_keyfsm
  import wdt_regif_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key1_i,
  input  logic key2_i,
  input  logic consume_i,
  input  logic byte_nonkey_i,
  output logic key_seen_o,
  output logic unlocked_o
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (key1_i)         state_d = KS_KEY1;
    else if (key2_i)    state_d = KS_OPEN;
    else if (consume_i) state_d = KS_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= KS_IDLE;
    else         state_q <= state_d;
  end

  assign key_seen_o = (state_q == KS_KEY1);
  assign unlocked_o = (state_q == KS_OPEN);

  assert_open_after_key_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == KS_OPEN && $past(state_q) != KS_OPEN) |-> $past(key2_i));

  assert_byte_keeps_state_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_nonkey_i |=> $stable(state_q));

  assert_key1_lands_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key1_i |=> state_q == KS_KEY1);
endmodule

// File: rtl/wdt_regif_wrdec.sv
module wdt_regif_wrdec
  import wdt_regif_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PRELOAD_W = 20,
  parameter logic [ADDR_W-1:0] OFS_S1  = 'h0,
  parameter logic [ADDR_W-1:0] OFS_S2  = 'h4,
  parameter logic [ADDR_W-1:0] OFS_RLD = 'hC
) (
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           size_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 key_seen_i,
  input  logic                 unlocked_i,
  output logic                 key1_o,
  output logic                 key2_o,
  output logic                 consume_o,
  output logic                 byte_nonkey_o,
  output logic                 ping_o,
  output logic                 clr_o,
  output logic                 ld1_o,
  output logic                 ld2_o,
  output logic [PRELOAD_W-1:0] ld_val_o
);
  logic [DATA_W-1:0] val;
  logic is_half, is_word, at_rld, nonkey;

  always_comb begin
    unique case (acc_size_e'(size_i))
      SZ_HALF: val = DATA_W'(wdata_i[15:0]);
      SZ_WORD: val = wdata_i;
      default: val = DATA_W'(wdata_i[7:0]);
    endcase
  end

  assign is_half = (size_i == SZ_HALF);
  assign is_word = (size_i == SZ_WORD);
  assign at_rld  = (addr_i == OFS_RLD);

  assign key1_o  = wr_en_i && at_rld && val == DATA_W'(KEY_FIRST);
  assign key2_o  = wr_en_i && at_rld && val == DATA_W'(KEY_SECOND) && key_seen_i;
  assign nonkey  = wr_en_i && !key1_o && !key2_o;
  assign consume_o     = nonkey && unlocked_i && (is_half || is_word);
  assign byte_nonkey_o = nonkey && !(is_half || is_word);

  assign ping_o   = consume_o && is_half && at_rld && wdata_i[PING_BIT];
  assign clr_o    = consume_o && is_half && at_rld &&
                    (wdata_i[CLR_BIT_A] || wdata_i[CLR_BIT_B]);
  assign ld1_o    = consume_o && is_word && addr_i == OFS_S1;
  assign ld2_o    = consume_o && is_word && addr_i == OFS_S2;
  assign ld_val_o = wdata_i[PRELOAD_W-1:0];

  always_comb begin
    assert_load_word_only_R6: assert (!(ld1_o || ld2_o) || is_word);
    assert_ping_half_only_R4: assert (!(ping_o || clr_o) || is_half);
    assert_locked_silent_R9: assert (unlocked_i || !(ping_o || clr_o || ld1_o || ld2_o));
  end
endmodule

// File: rtl/wdt_regif_rdmux.sv
module wdt_regif_rdmux
  import wdt_regif_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_RLD = 'hC
) (
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_en_i && size_i == SZ_HALF && addr_i == OFS_RLD) begin
      rdata_o[CLR_BIT_A] = flag_i;
      rdata_o[CLR_BIT_B] = flag_i;
    end
  end

  always_comb begin
    assert_flag_mirror_R10: assert (rdata_o[CLR_BIT_A] == rdata_o[CLR_BIT_B]);
    assert_idle_read_zero_R10: assert (rd_en_i || rdata_o == '0);
  end
endmodule

// File: rtl/wdt_regif.sv
module wdt_regif
  import wdt_regif_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 32,
  parameter int PRELOAD_W = 20
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [1:0]           size_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic                 flag_i,
  output logic                 ping_o,
  output logic                 clr_flag_o,
  output logic                 load_s1_o,
  output logic                 load_s2_o,
  output logic [PRELOAD_W-1:0] load_val_o
);
  localparam logic [ADDR_W-1:0] OFS_S1  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_S2  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_RLD = ADDR_W'(12);

  logic key1, key2, consume, byte_nonkey, key_seen, unlocked;

  wdt_regif_keyfsm u_fsm (
    .clk_i, .rst_ni,
    .key1_i(key1), .key2_i(key2), .consume_i(consume), .byte_nonkey_i(byte_nonkey),
    .key_seen_o(key_seen), .unlocked_o(unlocked)
  );

  wdt_regif_wrdec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRELOAD_W(PRELOAD_W),
    .OFS_S1(OFS_S1), .OFS_S2(OFS_S2), .OFS_RLD(OFS_RLD)
  ) u_dec (
    .wr_en_i, .addr_i, .size_i, .wdata_i,
    .key_seen_i(key_seen), .unlocked_i(unlocked),
    .key1_o(key1), .key2_o(key2), .consume_o(consume), .byte_nonkey_o(byte_nonkey),
    .ping_o, .clr_o(clr_flag_o), .ld1_o(load_s1_o), .ld2_o(load_s2_o),
    .ld_val_o(load_val_o)
  );

  wdt_regif_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_RLD(OFS_RLD)) u_rd (
    .rd_en_i, .addr_i, .size_i, .flag_i, .rdata_o
  );

  assert_action_relocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ping_o || clr_flag_o || load_s1_o || load_s2_o) |=> !unlocked);

  assert_pulse_with_write_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ping_o || clr_flag_o || load_s1_o || load_s2_o) |-> wr_en_i);

  assert_single_target_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({load_s1_o, load_s2_o, ping_o || clr_flag_o}));
endmodule

// File: tb/wdt_regif_test.sv
module wdt_regif_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0, flag_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        ping_o, clr_flag_o, load_s1_o, load_s2_o;
  logic [19:0] load_val_o;

  int n_chk = 0, n_bad = 0;
  int mstate = 0; // 0 idle, 1 first key, 2 unlocked

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wdt_regif uut (.*);

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pack_out();
    return {8'h0, rdata_o[7:0] | rdata_o[31:24], 4'h0, ping_o, clr_flag_o, load_s1_o, load_s2_o,
            12'h0, load_val_o, rdata_o[23:8]};
  endfunction

  // drive one write at negedge, compare against requirement-derived model, then clock
  task automatic do_write(logic [3:0] a, logic [1:0] s, logic [31:0] d);
    logic [31:0] v;
    logic k1, k2, hs, ws, cons, ep, ec, e1, e2;
    string tag;
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; size_i = s; wdata_i = d;
    v  = (s == 2'd1) ? {16'h0, d[15:0]} : (s == 2'd2) ? d : {24'h0, d[7:0]};
    hs = (s == 2'd1); ws = (s == 2'd2);
    k1 = (a == 4'hC) && v == 32'h80;
    k2 = (a == 4'hC) && v == 32'h86 && mstate == 1;
    cons = !k1 && !k2 && mstate == 2 && (hs || ws);
    ep = cons && hs && a == 4'hC && d[8];
    ec = cons && hs && a == 4'hC && (d[9] || d[12]);
    e1 = cons && ws && a == 4'h0;
    e2 = cons && ws && a == 4'h4;
    if (ep) tag = "R4"; else if (ec) tag = "R5"; else if (e1 || e2) tag = "R6";
    else if (s == 2'd3) tag = "R1"; else if (!(hs || ws)) tag = "R7";
    else if (k1) tag = "R2"; else if (k2) tag = "R3";
    else if (mstate == 2) tag = "R8"; else tag = "R9";
    #(CLK_PERIOD/4);
    check(tag, pack_out(),
          {8'h0, 8'h0, 4'h0, ep, ec, e1, e2, 12'h0, d[19:0], 16'h0});
    if (k1) mstate = 1; else if (k2) mstate = 2; else if (cons) mstate = 0;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    #(CLK_PERIOD/4);
    check("R11", {60'h0, ping_o, clr_flag_o, load_s1_o, load_s2_o}, 64'h0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    mstate = 0;
  endtask

  logic [31:0] vals [8] = '{32'h80, 32'h86, 32'h100, 32'h200, 32'h1000,
                           32'hABC12345, 32'h0, 32'h1386};

  initial begin
    repeat (2) @(negedge clk_i);
    #(CLK_PERIOD/4);
    check("R12", {59'h0, ping_o, clr_flag_o, load_s1_o, load_s2_o, |rdata_o}, 64'h0);
    rst_ni = 1'b1;
    // R12: after reset, a ping write without key is silent
    do_write(4'hC, 2'd1, 32'h100);

    for (int st = 0; st < 3; st++)
      for (int a = 0; a < 16; a++)
        for (int s = 0; s < 4; s++)
          for (int vi = 0; vi < 8; vi++) begin
            do_reset();
            if (st >= 1) do_write(4'hC, 2'd1, 32'h80);
            if (st == 2) do_write(4'hC, 2'd1, 32'h86);
            do_write(a[3:0], s[1:0], vals[vi]);
            // probe: reveals the key state left behind through the ping output
            do_write(4'hC, 2'd1, 32'h86);
            do_write(4'hC, 2'd1, 32'h100);
          end

    // R6: preload keeps exactly the low 20 bits, stage two
    do_reset();
    do_write(4'hC, 2'd2, 32'h80);
    do_write(4'hC, 2'd0, 32'h86);
    do_write(4'h4, 2'd2, 32'hFFF_5A5A5);

    // R10: read sweep
    for (int f = 0; f < 2; f++)
      for (int a = 0; a < 16; a++)
        for (int s = 0; s < 4; s++) begin
          @(negedge clk_i);
          rd_en_i = 1'b1; flag_i = f[0]; addr_i = a[3:0]; size_i = s[1:0];
          #(CLK_PERIOD/4);
          check("R10", {32'h0, rdata_o},
                (a == 12 && s == 1 && f == 1) ? 64'h1200 : 64'h0);
        end
    @(negedge clk_i);
    rd_en_i = 1'b0; flag_i = 1'b1;
    #(CLK_PERIOD/4);
    check("R10", {32'h0, rdata_o}, 64'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule